// File: doc/BRIEF.md
# Timestamped One-Time-Pad Line Cipher

This block sits between a cache and an external memory. It encrypts each 256-bit cache line on writeback and decrypts it on fill. Both the cache side and the memory side move data as 32-bit beats, eight beats per line. The block accepts one line transaction at a time.

For every transaction the block builds a 128-bit seed from three parts: a per-line timestamp, the line-aligned address, and a fixed padding constant. It sends the seed to an external keystream generator and receives a 128-bit pad in return. Each beat is XORed with one 32-bit word of that pad. The pad is used twice, once for each 128-bit half of the line.

Lines inside a read-write window keep a timestamp in an on-chip table. The window starts at the `rw_base` input and spans `TS_LINES` lines of 32 bytes. A write advances the line's timestamp, so two writes to the same line never use the same pad. Lines outside the window are treated as read-only: they use a zero timestamp, and the table is never touched for them.

On a read, the block looks the timestamp up first. It then asks for the pad in the same cycle as it starts the memory fetch, so pad generation overlaps the memory latency.

Top module: `otp_line_crypt`

## Requirements
- R1: A write to a line in the read-write window increments that line's table timestamp by one. The incremented value is stored back into the table and is the value carried in the seed of that write.
- R2: The seed is laid out as follows: bits [127:128-TS_W] hold the timestamp, the next AW bits down hold the line address with its low 5 bits zero, and the remaining low bits hold the low bits of PAD_RV.
- R3: Beat i of a line (i = 0..7) is XORed with pad bits [32*(i mod 4)+31 : 32*(i mod 4)], so the same 128-bit pad covers both halves of the line.
- R4: On a write, each plaintext beat from the cache leaves on `m_wdata` XORed with its pad word. On a read, each ciphertext beat from memory leaves on `c_rdata` XORed with its pad word. Reading back an unchanged line returns the original plaintext.
- R5: `p_req` and `m_start` are asserted together for one cycle, two cycles after `c_req` is accepted. A read leaves the line's timestamp unchanged.
- R6: An address below `rw_base`, or at or beyond `rw_base + 32*TS_LINES`, is read-only. It puts zero in the seed's timestamp field, and writing to it changes no table entry.
- R7: No beat is released on `c_rvalid` or `m_wvalid` before the pad has been received. Beats that arrive earlier are held and sent out in order once the pad is in.
- R8: Each transaction moves exactly 8 beats out, in the order they came in.
- R9: While `c_busy` is high, `c_req` is ignored. `c_done` pulses for one cycle after the last output beat has gone out and `m_done` has been seen. `c_busy` is low in that same cycle.
- R10: The timestamp wraps silently from all ones to zero. `ts_wrap` pulses for one cycle in the transaction where the wrap happens.
- R11: The table index is (address - `rw_base`)/32, so each line in the window keeps its own counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rw_base | input | AW | First byte address of the read-write window |
| c_req | input | 1 | Cache starts a line transaction |
| c_write | input | 1 | 1 = writeback (encrypt), 0 = fill (decrypt) |
| c_addr | input | AW | Byte address of the line |
| c_wvalid | input | 1 | Plaintext beat valid from cache |
| c_wdata | input | 32 | Plaintext beat from cache |
| c_busy | output | 1 | Transaction in progress |
| c_done | output | 1 | One-cycle completion pulse |
| c_rvalid | output | 1 | Decrypted beat valid to cache |
| c_rdata | output | 32 | Decrypted beat to cache |
| m_start | output | 1 | Starts the memory line access |
| m_we | output | 1 | Memory access is a write |
| m_addr | output | AW | Line-aligned memory address |
| m_wvalid | output | 1 | Ciphertext beat valid to memory |
| m_wdata | output | 32 | Ciphertext beat to memory |
| m_rvalid | input | 1 | Ciphertext beat valid from memory |
| m_rdata | input | 32 | Ciphertext beat from memory |
| m_done | input | 1 | Memory has finished the line access |
| p_req | output | 1 | Pad request to the keystream generator |
| p_seed | output | 128 | Seed for the keystream generator |
| p_valid | input | 1 | Pad response valid |
| p_pad | input | 128 | Pad response |
| ts_wrap | output | 1 | Timestamp wrapped in this write |

## Verification
The cipher path is driven with data beats that arrive well before the pad and with a pad that arrives before any data. The first case shows whether beats are held back correctly; the second shows whether the block adds any wait of its own. Write-then-read sequences on one line check that decryption restores the plaintext. They also check that repeated writes move the seed forward while reads leave it unchanged. Addresses just below, inside and beyond the window separate the read-write lines from the read-only ones. A burst of back-to-back writes to a single line takes a narrowed timestamp through its wrap. A request raised in the middle of a transaction must show no second seed and no effect on the counter of the address it named.

// File: rtl/otp_line_pkg.sv
package otp_line_pkg;

  localparam int BEAT_W     = 32;
  localparam int LINE_BEATS = 8;
  localparam int SLOT_W     = 3;
  localparam int CNT_W      = 4;
  localparam int PAD_W      = 128;
  localparam int LINE_BYTES = 32;
  localparam int LINE_SHIFT = 5;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_LOOK  = 2'd1,
    S_ISSUE = 2'd2,
    S_RUN   = 2'd3
  } txn_state_t;

  // mask of the n lowest bits of a 128-bit word
  function automatic logic [127:0] low_mask(input int n);
    if (n <= 0)   return '0;
    if (n >= 128) return '1;
    return (128'd1 << n) - 128'd1;
  endfunction

  // seed = timestamp on top, line address below it, padding in the rest
  function automatic logic [127:0] build_seed(input logic [63:0] ts, input int ts_w,
                                              input logic [63:0] addr, input int a_w,
                                              input logic [127:0] rv);
    int rv_w;
    logic [127:0] t;
    logic [127:0] a;
    rv_w = 128 - ts_w - a_w;
    t = {64'd0, ts} & low_mask(ts_w);
    a = {64'd0, addr} & low_mask(a_w);
    return (rv & low_mask(rv_w)) | (a << rv_w) | (t << (rv_w + a_w));
  endfunction

  // pad word used for a beat: same 128-bit pad for both line halves
  function automatic logic [31:0] pad_word(input logic [127:0] pad, input logic [1:0] sel);
    case (sel)
      2'd0:    return pad[31:0];
      2'd1:    return pad[63:32];
      2'd2:    return pad[95:64];
      default: return pad[127:96];
    endcase
  endfunction

endpackage

// File: rtl/otp_ts_table.sv
module otp_ts_table #(
  parameter int LINES = 16,
  parameter int TS_W  = 32,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TS_W-1:0]  rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TS_W-1:0]  wr_data
);

  logic [TS_W-1:0] stamp [LINES];

  assign rd_data = stamp[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) stamp[i] <= '0;
    end else if (wr_en) begin
      stamp[wr_idx] <= wr_data;
    end
  end

  // R1: a stored timestamp is exactly one above what the same entry held
  a_r1_ts_bump: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx == rd_idx) && (wr_data == rd_data + TS_W'(1)));

endmodule

// File: rtl/otp_beat_buffer.sv
module otp_beat_buffer
  import otp_line_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              in_valid,
  input  logic [BEAT_W-1:0] in_data,
  input  logic              pad_valid,
  input  logic [PAD_W-1:0]  pad_in,
  output logic              out_valid,
  output logic [BEAT_W-1:0] out_data,
  output logic              pad_known,
  output logic              all_out
);

  logic [BEAT_W-1:0] slot [LINE_BEATS];
  logic [CNT_W-1:0]  in_cnt;
  logic [CNT_W-1:0]  out_cnt;
  logic [PAD_W-1:0]  pad_q;
  logic              take_in;
  logic              emit;

  assign take_in = in_valid && (in_cnt < CNT_W'(LINE_BEATS));
  assign emit    = pad_known && (out_cnt < in_cnt);
  assign all_out = (out_cnt == CNT_W'(LINE_BEATS));

  always_ff @(posedge clk) begin
    if (take_in) slot[in_cnt[SLOT_W-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cnt    <= '0;
      out_cnt   <= '0;
      pad_known <= 1'b0;
      pad_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (clear) begin
      in_cnt    <= '0;
      out_cnt   <= '0;
      pad_known <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (take_in) in_cnt <= in_cnt + CNT_W'(1);
      if (pad_valid && !pad_known) begin
        pad_known <= 1'b1;
        pad_q     <= pad_in;
      end
      out_valid <= emit;
      if (emit) begin
        out_data <= slot[out_cnt[SLOT_W-1:0]] ^ pad_word(pad_q, out_cnt[1:0]);
        out_cnt  <= out_cnt + CNT_W'(1);
      end
    end
  end

  // R7: a beat only leaves once a pad has been captured
  a_r7_pad_before_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pad_known);

  // R8: never more than one line in, never more out than in
  a_r8_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt <= CNT_W'(LINE_BEATS)) && (out_cnt <= in_cnt));

endmodule

// File: rtl/otp_line_crypt.sv
module otp_line_crypt
  import otp_line_pkg::*;
#(
  parameter int           AW       = 32,
  parameter int           TS_W     = 32,
  parameter int           TS_LINES = 16,
  parameter logic [127:0] PAD_RV   = 128'h3C6E_F372_A54F_F53A_510E_527F_9B05_688C,
  localparam int          IDX_W    = (TS_LINES > 1) ? $clog2(TS_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rw_base,
  input  logic              c_req,
  input  logic              c_write,
  input  logic [AW-1:0]     c_addr,
  input  logic              c_wvalid,
  input  logic [BEAT_W-1:0] c_wdata,
  output logic              c_busy,
  output logic              c_done,
  output logic              c_rvalid,
  output logic [BEAT_W-1:0] c_rdata,
  output logic              m_start,
  output logic              m_we,
  output logic [AW-1:0]     m_addr,
  output logic              m_wvalid,
  output logic [BEAT_W-1:0] m_wdata,
  input  logic              m_rvalid,
  input  logic [BEAT_W-1:0] m_rdata,
  input  logic              m_done,
  output logic              p_req,
  output logic [PAD_W-1:0]  p_seed,
  input  logic              p_valid,
  input  logic [PAD_W-1:0]  p_pad,
  output logic              ts_wrap
);

  localparam logic [AW-1:0] LINE_MASK = AW'(LINE_BYTES - 1);
  localparam logic [AW-1:0] LINES_AW  = AW'(TS_LINES);

  txn_state_t        state;
  logic [AW-1:0]     addr_q;
  logic              we_q;
  logic [TS_W-1:0]   ts_q;
  logic              mdone_seen;
  logic              done_q;
  logic              wrap_q;

  logic [AW-1:0]     off_lines;
  logic              rw_hit;
  logic [IDX_W-1:0]  ts_idx;
  logic [TS_W-1:0]   ts_rd;
  logic [TS_W-1:0]   ts_next;
  logic              ts_wr_en;

  logic              buf_clear;
  logic              buf_in_valid;
  logic [BEAT_W-1:0] buf_in_data;
  logic              pad_take;
  logic              out_valid;
  logic [BEAT_W-1:0] out_data;
  logic              pad_known;
  logic              all_out;
  logic              finish;

  // region decode and table index
  always_comb begin
    off_lines = (addr_q - rw_base) >> LINE_SHIFT;
    rw_hit    = (addr_q >= rw_base) && (off_lines < LINES_AW);
    ts_idx    = off_lines[IDX_W-1:0];
  end

  assign ts_next  = ts_rd + TS_W'(1);
  assign ts_wr_en = (state == S_LOOK) && we_q && rw_hit;

  otp_ts_table #(.LINES(TS_LINES), .TS_W(TS_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (ts_idx),
    .rd_data (ts_rd),
    .wr_en   (ts_wr_en),
    .wr_idx  (ts_idx),
    .wr_data (ts_next)
  );

  // beat path shared by both directions
  assign buf_clear    = (state == S_IDLE) && c_req;
  assign buf_in_valid = (state != S_IDLE) && (we_q ? c_wvalid : m_rvalid);
  assign buf_in_data  = we_q ? c_wdata : m_rdata;
  assign pad_take     = p_valid && ((state == S_ISSUE) || (state == S_RUN));

  otp_beat_buffer u_beats (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (buf_clear),
    .in_valid  (buf_in_valid),
    .in_data   (buf_in_data),
    .pad_valid (pad_take),
    .pad_in    (p_pad),
    .out_valid (out_valid),
    .out_data  (out_data),
    .pad_known (pad_known),
    .all_out   (all_out)
  );

  assign finish = (state == S_RUN) && all_out && (mdone_seen || m_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      addr_q     <= '0;
      we_q       <= 1'b0;
      ts_q       <= '0;
      mdone_seen <= 1'b0;
      done_q     <= 1'b0;
      wrap_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      wrap_q <= 1'b0;
      case (state)
        S_IDLE: if (c_req) begin
          addr_q     <= c_addr & ~LINE_MASK;
          we_q       <= c_write;
          mdone_seen <= 1'b0;
          state      <= S_LOOK;
        end
        S_LOOK: begin
          ts_q   <= rw_hit ? (we_q ? ts_next : ts_rd) : '0;
          wrap_q <= ts_wr_en && (ts_next == '0);
          state  <= S_ISSUE;
        end
        S_ISSUE: begin
          if (m_done) mdone_seen <= 1'b1;
          state <= S_RUN;
        end
        S_RUN: begin
          if (m_done) mdone_seen <= 1'b1;
          if (finish) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign c_busy   = (state != S_IDLE);
  assign c_done   = done_q;
  assign c_rvalid = out_valid && !we_q;
  assign c_rdata  = out_data;
  assign m_wvalid = out_valid && we_q;
  assign m_wdata  = out_data;
  assign m_start  = (state == S_ISSUE);
  assign m_we     = we_q;
  assign m_addr   = addr_q;
  assign p_req    = (state == S_ISSUE);
  assign p_seed   = build_seed(64'(ts_q), TS_W, 64'(addr_q), AW, PAD_RV);
  assign ts_wrap  = wrap_q;

  // R5: pad request and memory start together, right after the lookup
  a_r5_pad_with_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    p_req |-> m_start && $past(state == S_LOOK));

  // R6: a read-only line carries a zero timestamp into the seed
  a_r6_ro_zero_ts: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_ISSUE) && !rw_hit) |-> (ts_q == '0));

  // R10: the wrap flag only appears with a zero timestamp
  a_r10_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ts_wrap |-> (ts_q == '0));

  // R9: completion ends a busy period and lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    c_done |-> !c_busy && $past(c_busy));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    c_done |=> !c_done);

endmodule

// File: tb/otp_line_crypt_bench.sv
module otp_line_crypt_bench;

  localparam int           TSW   = 4;
  localparam int           LINES = 4;
  localparam logic [31:0]  BASE  = 32'h0000_1000;
  localparam logic [127:0] RV    = 128'hDEAD_BEEF_0BAD_F00D_1357_9BDF_2468_ACE0;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [31:0]  rw_base;
  logic         c_req, c_write, c_wvalid;
  logic [31:0]  c_addr, c_wdata;
  logic         c_busy, c_done, c_rvalid;
  logic [31:0]  c_rdata;
  logic         m_start, m_we, m_wvalid;
  logic [31:0]  m_addr, m_wdata;
  logic         m_rvalid, m_done;
  logic [31:0]  m_rdata;
  logic         p_req, p_valid;
  logic [127:0] p_seed, p_pad;
  logic         ts_wrap;

  always #5 clk = ~clk;

  otp_line_crypt #(.AW(32), .TS_W(TSW), .TS_LINES(LINES), .PAD_RV(RV)) u_otp_line_crypt (
    .clk(clk), .rst_n(rst_n), .rw_base(rw_base),
    .c_req(c_req), .c_write(c_write), .c_addr(c_addr), .c_wvalid(c_wvalid), .c_wdata(c_wdata),
    .c_busy(c_busy), .c_done(c_done), .c_rvalid(c_rvalid), .c_rdata(c_rdata),
    .m_start(m_start), .m_we(m_we), .m_addr(m_addr), .m_wvalid(m_wvalid), .m_wdata(m_wdata),
    .m_rvalid(m_rvalid), .m_rdata(m_rdata), .m_done(m_done),
    .p_req(p_req), .p_seed(p_seed), .p_valid(p_valid), .p_pad(p_pad), .ts_wrap(ts_wrap)
  );

  int n_chk = 0;
  int n_bad = 0;
  int ts_m [LINES];
  logic [255:0] ext_m   [logic [31:0]];
  logic [255:0] plain_m [logic [31:0]];

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // behavioural keystream stand-in
  function automatic logic [127:0] pad_fn(input logic [127:0] s);
    return {s[100:0], s[127:101]} ^ {4{s[31:0] ^ 32'h9E37_79B9}} ^ 128'h5A5A_0F0F_3C3C_C3C3_A5A5_F0F0_6969_9696;
  endfunction

  task automatic idle_inputs();
    c_req = 0; c_write = 0; c_addr = '0; c_wvalid = 0; c_wdata = '0;
    m_rvalid = 0; m_rdata = '0; m_done = 0; p_valid = 0; p_pad = '0;
  endtask

  task automatic run_line(input bit we, input logic [31:0] addr, input logic [255:0] pdata,
                          input int pad_lat, input int beat_lat, input bit poke);
    logic [31:0]  line;
    bit           rw, exp_wrap, wrap_seen, fin, wdone_sent;
    int           idx, exp_ts, cyc, preq_cyc, pad_cyc, npreq, ob, wi, ri;
    logic [127:0] seed, pad;
    logic [255:0] src, got;
    line = addr & ~32'h1F;
    rw   = (line >= BASE) && (((line - BASE) >> 5) < LINES);
    idx  = rw ? int'((line - BASE) >> 5) : 0;
    exp_ts = rw ? ts_m[idx] : 0;
    exp_wrap = 0;
    if (we && rw) begin
      exp_ts = (exp_ts + 1) % (1 << TSW);
      ts_m[idx] = exp_ts;
      exp_wrap = (exp_ts == 0);
    end
    seed = {exp_ts[TSW-1:0], line, RV[127-TSW-32:0]};
    pad  = pad_fn(seed);
    if (we) src = pdata;
    else if (ext_m.exists(line)) src = ext_m[line];
    else src = {8{line ^ 32'hC0DE_0000}};
    preq_cyc = -1; pad_cyc = -1; npreq = 0; ob = 0; wi = 0; ri = 0;
    wrap_seen = 0; fin = 0; wdone_sent = 0; got = '0; cyc = 0;
    while (!fin && cyc < 100) begin
      @(negedge clk);
      // sample
      if (p_req) begin
        npreq++;
        check(cyc == 2, "R5 pad request timing", 256'(cyc), 256'd2);
        check(m_start, "R5 fetch with pad request", 256'(m_start), 256'd1);
        check(p_seed == seed, we ? (rw ? "R1 seed" : "R6 seed") : (rw ? "R2 seed" : "R6 seed"),
              256'(p_seed), 256'(seed));
        if (preq_cyc < 0) preq_cyc = cyc;
      end
      if (m_start) check((m_addr == line) && (m_we == we), "R5 memory address",
                         256'({m_we, m_addr}), 256'({we, line}));
      if (ts_wrap) wrap_seen = 1;
      if (c_rvalid || m_wvalid) begin
        check(pad_cyc >= 0 && cyc > pad_cyc, "R7 beat before pad", 256'(cyc), 256'(pad_cyc));
        check(we ? (m_wvalid && !c_rvalid) : (c_rvalid && !m_wvalid), "R4 beat direction",
              256'({c_rvalid, m_wvalid}), 256'(we ? 2'b01 : 2'b10));
        if (ob < 8) begin
          check((we ? m_wdata : c_rdata) == (src[32*ob +: 32] ^ pad[32*(ob%4) +: 32]), "R3 beat data",
                256'(we ? m_wdata : c_rdata), 256'(src[32*ob +: 32] ^ pad[32*(ob%4) +: 32]));
          got[32*ob +: 32] = we ? m_wdata : c_rdata;
        end
        ob++;
      end
      if (c_done) begin
        fin = 1;
        check(ob == 8, "R8 beat count", 256'(ob), 256'd8);
        check(!c_busy, "R9 idle at done", 256'(c_busy), 256'd0);
      end
      // drive
      idle_inputs();
      if (!fin) begin
        if (cyc == 0 || (poke && cyc == 4)) begin
          c_req = 1; c_write = 1;
          c_addr = (cyc == 0) ? addr : BASE + 32'd96;
          if (cyc == 0) c_write = we;
        end
        if (we && cyc >= 1 + beat_lat && wi < 8) begin
          c_wvalid = 1; c_wdata = pdata[32*wi +: 32]; wi++;
        end
        if (preq_cyc >= 0 && pad_cyc < 0 && cyc >= preq_cyc + pad_lat) begin
          p_valid = 1; p_pad = pad; pad_cyc = cyc;
        end
        if (!we && preq_cyc >= 0 && cyc >= preq_cyc + beat_lat && ri < 8) begin
          m_rvalid = 1; m_rdata = src[32*ri +: 32]; ri++;
          if (ri == 8) m_done = 1;
        end
        if (we && ob == 8 && !wdone_sent) begin
          m_done = 1; wdone_sent = 1;
        end
      end
      cyc++;
    end
    check(fin, "R9 transaction completes", 256'(fin), 256'd1);
    check(npreq == 1, "R9 single pad request", 256'(npreq), 256'd1);
    check(wrap_seen == exp_wrap, "R10 wrap flag", 256'(wrap_seen), 256'(exp_wrap));
    if (we) begin
      ext_m[line] = got;
      plain_m[line] = pdata;
    end else if (plain_m.exists(line)) begin
      check(got == plain_m[line], "R4 round trip", got, plain_m[line]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 256'd0, 256'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < LINES; i++) ts_m[i] = 0;
    rw_base = BASE;
    rst_n = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!c_busy && !c_done && !p_req && !m_start && !ts_wrap && !c_rvalid && !m_wvalid,
          "R9 reset state", 256'({c_busy, c_done, p_req, m_start, ts_wrap, c_rvalid, m_wvalid}), 256'd0);

    // R7: write beats arrive long before the pad
    run_line(1, BASE, {8{32'h1111_2222}} ^ 256'h0123_4567_89AB_CDEF, 6, 0, 0);
    // R4 R5: read back with pad first, data later; timestamp unchanged
    run_line(0, BASE, '0, 0, 5, 0);
    // R1: second write to the same line advances the seed
    run_line(1, BASE + 32'h4, {4{64'hFEDC_BA98_7654_3210}}, 0, 2, 0);
    run_line(0, BASE, '0, 7, 0, 0);
    // R11 R9: another line, with a request poked in mid-transaction
    run_line(1, BASE + 32'd32, {8{32'hA5A5_5A5A}}, 2, 1, 1);
    run_line(0, BASE + 32'd32, '0, 1, 1, 0);
    // R9 R11: line named by the ignored request still has timestamp zero
    run_line(0, BASE + 32'd96, '0, 0, 0, 0);
    // R6: below and beyond the read-write window
    run_line(0, BASE - 32'd32, '0, 3, 0, 0);
    run_line(1, BASE + 32'(LINES * 32), {8{32'h0F1E_2D3C}}, 1, 0, 0);
    run_line(0, BASE + 32'(LINES * 32), '0, 0, 2, 0);
    // R10: drive one line through its timestamp wrap
    for (int k = 0; k < 16; k++)
      run_line(1, BASE + 32'd64, {8{32'(k * 32'h0101_0101)}} ^ 256'hBEEF, k % 3, k % 4, 0);
    run_line(0, BASE + 32'd64, '0, 2, 2, 0);
    @(negedge clk);
    check(!c_busy, "R9 idle after sequence", 256'(c_busy), 256'd0);
    finish_run();
  end

endmodule